// File: doc/BRIEF.md
# Hit Memory with Token-Ring Readout

This block is the digital back end of a multichannel discriminator readout chip. The block runs two phases. While acquisition is enabled, a free-running crossing counter advances once per clock. On every cycle in which at least one channel discriminator is active, the block writes one complete record to an on-chip event memory. Each record holds the two-bit state of every channel, the crossing number and an identifying header. Channels that did not fire are still stored.

Readout is shared by many chips placed on a ring. A chip in readout waits for a token pulse. It then shifts out every stored record as a serial bit stream, emits a one-cycle token pulse towards the next chip and empties its memory. A chip with an empty memory forwards the token straight away. The readout state machine has four states:

- `RO_IDLE`: readout is not requested.
- `RO_ARMED`: waiting for the token.
- `RO_SEND`: shifting out the records.
- `RO_PASS`: emitting the token pulse and clearing the memory.

The transitions are as follows:

- idle→armed happens when readout is enabled and acquisition is off.
- armed→idle happens when readout is withdrawn or acquisition restarts.
- armed→send happens when the token arrives and records are present.
- armed→pass happens when the token arrives and the memory is empty.
- send→pass happens after the last bit of the last record.
- pass→idle always happens on the next cycle.

Top module: `hm_token_readout`

## Requirements
- R1: After reset, `mem_full`, `ser_valid` and `token_out` are all 0.
- R2: A record is written on each clock edge at which `acq_en` is 1, the state machine is idle, the memory is not full and `disc` is nonzero. An all-zero `disc` writes nothing.
- R3: The crossing number captured with a record equals the number of earlier consecutive cycles in the same run of `acq_en`=1. It is therefore 0 in the first cycle of a run, and the count restarts from 0 whenever `acq_en` has been low.
- R4: Each record is sent most significant bit first in this order: the 8-bit `chip_id` header, then the crossing number, then the channels from channel NCH-1 down to channel 0. Within a channel, bit 1 is sent before bit 0, and channel c occupies `disc[2c+1:2c]`.
- R5: Once DEPTH records are stored, `mem_full` is 1 and further hits are dropped. The readout then carries exactly DEPTH records.
- R6: The token is accepted only when `ro_en` is 1 and `acq_en` is 0. A token that arrives while acquisition runs produces neither `ser_valid` nor `token_out`.
- R7: In the cycle after an accepted token, `ser_valid` rises. It then stays 1 for exactly count×record-width cycles, and the records come out in the order they were written.
- R8: `token_out` is a single-cycle pulse in the cycle right after the last serial bit, and `ser_valid` is 0 during that pulse.
- R9: A chip holding no records raises `token_out` in the cycle right after the token is accepted.
- R10: After `token_out`, the memory is empty: `mem_full` is 0, and a following token is forwarded as for an empty chip.
- R11: A token pulse that arrives during serial transmission has no effect on the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acq_en | input | 1 | Acquisition active |
| disc | input | 2*NCH | Discriminator states, channel c in bits 2c+1:2c |
| chip_id | input | HDR_W | Static header value |
| ro_en | input | 1 | Readout requested |
| token_in | input | 1 | Token pulse from the previous chip |
| ser_out | output | 1 | Serial record data |
| ser_valid | output | 1 | Serial data valid |
| token_out | output | 1 | Token pulse to the next chip |
| mem_full | output | 1 | Event memory holds DEPTH records |

## Verification
Two functions can meet in a single cycle: capturing a hit, and taking the token for readout. The bench provokes this by holding `ro_en` high and toggling `token_in` on the very cycles in which hits are captured. It judges the result in two ways. First, the serial outputs must stay silent throughout. Second, the later readout must return every captured record with its crossing number unchanged. The bench also sends a token in the middle of a transmission and checks that the stream continues intact.

// File: rtl/hm_pkg.sv
package hm_pkg;
    typedef enum logic [1:0] {
        RO_IDLE  = 2'd0,
        RO_ARMED = 2'd1,
        RO_SEND  = 2'd2,
        RO_PASS  = 2'd3
    } ro_state_t;
endpackage

// File: rtl/hm_bcid_counter.sv
module hm_bcid_counter #(
    parameter int BCID_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    output logic [BCID_W-1:0] bcid
);
    // Crossing number: cleared whenever acquisition is off.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            bcid <= '0;
        else if (!run)
            bcid <= '0;
        else
            bcid <= bcid + BCID_W'(1);
    end
endmodule

// File: rtl/hm_hit_detect.sv
module hm_hit_detect #(
    parameter int NCH = 64
) (
    input  logic [2*NCH-1:0] disc,
    output logic             hit
);
    logic [NCH-1:0] ch_fire;

    // Per-channel fire flag: either discriminator bit of the channel is set.
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign ch_fire[c] = disc[2*c] | disc[2*c+1];
    end

    assign hit = |ch_fire;
endmodule

// File: rtl/hm_event_store.sv
module hm_event_store #(
    parameter int DEPTH = 128,
    parameter int W     = 160,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_rec,
    input  logic          clr,
    input  logic [AW-1:0] rd_idx,
    output logic [W-1:0]  rd_rec,
    output logic [CW-1:0] count,
    output logic          full
);
    logic [W-1:0] mem [DEPTH];
    logic         do_write;

    assign full     = (count == CW'(DEPTH));
    assign do_write = wr_en && !full;

    // Record count doubles as the write pointer.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= '0;
        else if (clr)
            count <= '0;
        else if (do_write)
            count <= count + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (do_write)
            mem[count[AW-1:0]] <= wr_rec;
    end

    assign rd_rec = mem[rd_idx];
endmodule

// File: rtl/hm_readout_fsm.sv
module hm_readout_fsm
    import hm_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int W     = 160,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int BW   = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ro_en,
    input  logic          acq_en,
    input  logic          token_in,
    input  logic [CW-1:0] count,
    input  logic [W-1:0]  rd_rec,
    output logic [AW-1:0] rd_idx,
    output logic          ser_out,
    output logic          ser_valid,
    output logic          token_out,
    output logic          store_clr,
    output logic          busy
);
    ro_state_t     state, state_nx;
    logic [BW-1:0] bit_idx;
    logic          last_bit, last_rec;

    assign last_bit = (bit_idx == '0);
    assign last_rec = ((CW'(rd_idx) + CW'(1)) == count);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= RO_IDLE;
        else
            state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            RO_IDLE: begin
                if (ro_en && !acq_en)
                    state_nx = RO_ARMED;
            end
            RO_ARMED: begin
                if (!ro_en || acq_en)
                    state_nx = RO_IDLE;
                else if (token_in)
                    state_nx = (count == '0) ? RO_PASS : RO_SEND;
            end
            RO_SEND: begin
                if (last_bit && last_rec)
                    state_nx = RO_PASS;
            end
            RO_PASS: begin
                state_nx = RO_IDLE;
            end
            default: state_nx = RO_IDLE;
        endcase
    end

    // Bit and record position within the stream
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_idx <= '0;
            rd_idx  <= '0;
        end else if (state == RO_ARMED) begin
            bit_idx <= BW'(W - 1);
            rd_idx  <= '0;
        end else if (state == RO_SEND) begin
            if (last_bit) begin
                bit_idx <= BW'(W - 1);
                rd_idx  <= rd_idx + AW'(1);
            end else begin
                bit_idx <= bit_idx - BW'(1);
            end
        end
    end

    // Output logic
    always_comb begin
        ser_valid = 1'b0;
        ser_out   = 1'b0;
        token_out = 1'b0;
        store_clr = 1'b0;
        busy      = 1'b1;
        unique case (state)
            RO_IDLE:  busy = 1'b0;
            RO_ARMED: ;
            RO_SEND: begin
                ser_valid = 1'b1;
                ser_out   = rd_rec[bit_idx];
            end
            RO_PASS: begin
                token_out = 1'b1;
                store_clr = 1'b1;
            end
            default: busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/hm_token_readout.sv
module hm_token_readout #(
    parameter int NCH    = 64,
    parameter int BCID_W = 24,
    parameter int HDR_W  = 8,
    parameter int DEPTH  = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acq_en,
    input  logic [2*NCH-1:0] disc,
    input  logic [HDR_W-1:0] chip_id,
    input  logic             ro_en,
    input  logic             token_in,
    output logic             ser_out,
    output logic             ser_valid,
    output logic             token_out,
    output logic             mem_full
);
    localparam int W  = HDR_W + BCID_W + 2 * NCH;
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [BCID_W-1:0] bcid;
    logic              hit, busy, store_clr, wr_en;
    logic [W-1:0]      wr_rec, rd_rec;
    logic [AW-1:0]     rd_idx;
    logic [CW-1:0]     count;

    hm_bcid_counter #(.BCID_W(BCID_W)) u_bcid (
        .clk(clk), .rst_n(rst_n), .run(acq_en), .bcid(bcid)
    );

    hm_hit_detect #(.NCH(NCH)) u_hit (
        .disc(disc), .hit(hit)
    );

    // Captures are blocked whenever the readout machine is active.
    assign wr_en  = acq_en && hit && !busy;
    assign wr_rec = {chip_id, bcid, disc};

    hm_event_store #(.DEPTH(DEPTH), .W(W)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_rec(wr_rec),
        .clr(store_clr), .rd_idx(rd_idx), .rd_rec(rd_rec),
        .count(count), .full(mem_full)
    );

    hm_readout_fsm #(.DEPTH(DEPTH), .W(W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .ro_en(ro_en), .acq_en(acq_en),
        .token_in(token_in), .count(count), .rd_rec(rd_rec),
        .rd_idx(rd_idx), .ser_out(ser_out), .ser_valid(ser_valid),
        .token_out(token_out), .store_clr(store_clr), .busy(busy)
    );
endmodule

// File: rtl/hm_token_readout_chk.sv
module hm_token_readout_chk (
    input logic clk,
    input logic rst_n,
    input logic acq_en,
    input logic ro_en,
    input logic token_in,
    input logic ser_valid,
    input logic token_out,
    input logic mem_full
);
    assert_token_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        token_out |=> !token_out);

    assert_token_not_with_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(token_out && ser_valid));

    assert_start_needs_token_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_valid) |-> $past(token_in && ro_en && !acq_en));

    assert_stream_ends_in_token_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ser_valid) |-> token_out);

    assert_full_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_full && !token_out) |=> mem_full);

    assert_cleared_after_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
        token_out |=> !mem_full);
endmodule

bind hm_token_readout hm_token_readout_chk u_chk (
    .clk(clk), .rst_n(rst_n), .acq_en(acq_en), .ro_en(ro_en),
    .token_in(token_in), .ser_valid(ser_valid), .token_out(token_out),
    .mem_full(mem_full)
);

// File: tb/hm_token_readout_bench.sv
`timescale 1ns/1ps
module hm_token_readout_bench;
    localparam int NCH    = 2;
    localparam int BCID_W = 6;
    localparam int HDR_W  = 8;
    localparam int DEPTH  = 4;
    localparam int W      = HDR_W + BCID_W + 2 * NCH;
    localparam logic [HDR_W-1:0] CHIP = 8'hA5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             acq_en = 1'b0;
    logic [2*NCH-1:0] disc = '0;
    logic [HDR_W-1:0] chip_id = CHIP;
    logic             ro_en = 1'b0;
    logic             token_in = 1'b0;
    logic             ser_out, ser_valid, token_out, mem_full;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] exp_q [DEPTH];
    int exp_n = 0;

    always #10 clk = ~clk;

    hm_token_readout #(.NCH(NCH), .BCID_W(BCID_W), .HDR_W(HDR_W), .DEPTH(DEPTH)) u_hm_token_readout (
        .clk(clk), .rst_n(rst_n), .acq_en(acq_en), .disc(disc), .chip_id(chip_id),
        .ro_en(ro_en), .token_in(token_in), .ser_out(ser_out), .ser_valid(ser_valid),
        .token_out(token_out), .mem_full(mem_full)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One acquisition run; pattern of cycle i is base+i. With ro_tok the
    // readout request and token toggle during the run (R6).
    task automatic acq(input int n, input int base, input bit ro_tok);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (ro_tok && i > 0)
                chk(!ser_valid && !token_out, "R6 token during acquisition", {ser_valid, token_out}, 0);
            acq_en = 1'b1;
            disc   = (2*NCH)'(base + i);
            if (ro_tok) begin
                ro_en    = 1'b1;
                token_in = ~token_in;
            end
            if (disc != '0 && exp_n < DEPTH) begin
                exp_q[exp_n] = {CHIP, BCID_W'(i), disc};
                exp_n++;
            end
        end
        @(negedge clk);
        if (ro_tok)
            chk(!ser_valid && !token_out, "R6 token during acquisition", {ser_valid, token_out}, 0);
        acq_en   = 1'b0;
        disc     = '0;
        token_in = 1'b0;
    endtask

    task automatic readout(input bit mid_tok);
        logic [W-1:0] rec;
        int vbad;
        @(negedge clk); ro_en = 1'b1;
        @(negedge clk); token_in = 1'b1;
        @(negedge clk); token_in = 1'b0;
        if (exp_n == 0) begin
            chk(token_out && !ser_valid, "R9 R10 empty chip passes token", {ser_valid, token_out}, 1);
        end else begin
            vbad = 0;
            for (int r = 0; r < exp_n; r++) begin
                rec = '0;
                for (int b = W - 1; b >= 0; b--) begin
                    if (!ser_valid) vbad++;
                    rec[b] = ser_out;
                    token_in = (mid_tok && r == 0 && b == W - 3);
                    @(negedge clk);
                end
                chk(rec == exp_q[r], "R2 R3 R4 R7 R11 record content", 64'(rec), 64'(exp_q[r]));
            end
            token_in = 1'b0;
            chk(vbad == 0, "R7 valid throughout stream", vbad, 0);
            chk(token_out && !ser_valid, "R8 token after last bit", {ser_valid, token_out}, 1);
        end
        ro_en = 1'b0;
        @(negedge clk);
        chk(!token_out, "R8 token is one cycle", token_out, 0);
        chk(!mem_full, "R10 memory cleared", mem_full, 0);
        exp_n = 0;
    endtask

    initial begin
        #(4_000_000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!mem_full && !ser_valid && !token_out, "R1 reset state",
            {mem_full, ser_valid, token_out}, 0);

        readout(1'b0);                       // R9 on a fresh chip

        // Sweep all 16 discriminator patterns in four runs of four cycles.
        for (int r = 0; r < 4; r++) begin
            acq(4, 4 * r, 1'b0);
            readout(r == 1);                 // R11 on the second run
            if (r == 0) readout(1'b0);       // R10: emptied memory forwards token
        end

        // Overfill: seven hits, only four kept (R5).
        acq(7, 5, 1'b0);
        @(negedge clk);
        chk(mem_full, "R5 full flag after DEPTH records", mem_full, 1);
        readout(1'b0);

        // Token and readout request coinciding with captures (R6).
        acq(3, 1, 1'b1);
        readout(1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule